// File: doc/BRIEF.md
# Single-Bus Microcoded Datapath

The block is a small processor datapath sequenced one row at a time by horizontal microcode. Every transfer between registers travels over one shared internal bus. The registers are an instruction register, a program counter, two user registers, an operand register, a result register, a memory address register and a memory data register. A combinational arithmetic unit adds, subtracts, increments and decrements. Each microword holds one switch bit for every register-to-bus or bus-to-register path, plus an arithmetic function field and a memory function field.

External memory sits behind a request/done handshake with any latency. Reads and writes leave at the end of the row that issues them. A wait row freezes the microprogram until the outstanding operation completes. Rows run strictly in sequence from a small internal store, and the sequence wraps to row 0 after the last row. The store is filled through a write port, normally while the block is held in reset.

Top module: `seqbus_core`

## Requirements
- R1: While rst_ni is low, every datapath register, the microprogram counter and the pending-memory flag are cleared. After reset, upc_o is 0, mem_req_o is low and bus_o is 0.
- R2: The bus carries the value of the single register whose drive bit is set in the current row, or zero if no drive bit is set. In that same row, any number of registers may load the bus value.
- R3: When the instruction address-field drive bit is set, the bus carries the low 12 bits of the instruction register. The upper bus bits are zero.
- R4: With the unit-input bit set, the function field writes a 16-bit result, modulo 2^16, into the result register at the end of the row. The codes are: 1 add (operand + bus), 2 subtract (operand - bus), 3 increment (bus + 1), 4 decrement (bus - 1).
- R5: A function code in a row whose unit-input bit is clear leaves the result register unchanged. Codes 0 and 5 to 7 also leave it unchanged.
- R6: A read (memory code 1) or write (memory code 2) is issued at the end of its row. It uses the address register and data register values as that row updates them. mem_req_o and the address stay steady until mem_done_i. On a read, the data register captures mem_rdata_i in the done cycle.
- R7: A wait row (memory code 3) holds the microprogram counter, and suppresses its own transfers, until an outstanding operation completes. It completes in the cycle mem_done_i arrives, or at once if nothing is outstanding.
- R8: A read or write row that meets a still-outstanding earlier operation is held until that operation completes, and then launches.
- R9: Every completed row advances the microprogram counter by one. The counter wraps from the last row (15) to row 0.
- R10: A store word has this layout. Bit 0 loads the instruction register. Bit 1 drives the address field. Bit 2 drives the result register. Bit 3 is the unit input. Bit 4 drives the PC and bit 5 loads it. Bits 6 and 7 drive and load R1. Bits 8 and 9 drive and load R2. Bit 10 loads the operand register. Bit 11 loads the address register. Bits 12 and 13 drive and load the data register. Bits 16:14 hold the function code and bits 18:17 the memory code. uc_we_i writes uc_data_i into row uc_addr_i.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| uc_we_i | input | 1 | Store row write enable |
| uc_addr_i | input | 4 | Store row being written |
| uc_data_i | input | 19 | Microword written to the store |
| mem_req_o | output | 1 | Memory operation outstanding |
| mem_we_o | output | 1 | Outstanding operation is a write |
| mem_addr_o | output | 16 | Memory address |
| mem_wdata_o | output | 16 | Write data |
| mem_rdata_i | input | 16 | Read data, valid with done |
| mem_done_i | input | 1 | Memory operation complete |
| bus_o | output | 16 | Internal bus value |
| upc_o | output | 4 | Microprogram counter |

## Verification
The assertions check the following on every cycle:
- a completed row drives the bus from at most one source;
- the address-field drive leaves the upper bus bits zero;
- the counter advances or wraps when a row completes and holds when it stalls;
- a pending request keeps its address and direction until done;
- a read completion lands in the data register.

The bench runs a sixteen-row program that fetches an instruction, fetches an operand through its address field, subtracts, adds, decrements and writes results back. It runs this program across memory latencies and operand pairs that include wrap-around. Only these scenarios show the arithmetic values, the ignored function code, the exact stall lengths, and whether the launch-time address and data land in memory.

// File: rtl/seqbus_pkg.sv
package seqbus_pkg;

  typedef enum logic [2:0] {
    ALU_NOP = 3'd0,
    ALU_ADD = 3'd1,
    ALU_SUB = 3'd2,
    ALU_INC = 3'd3,
    ALU_DEC = 3'd4
  } alu_fn_e;

  typedef enum logic [1:0] {
    MEM_NOP  = 2'd0,
    MEM_RD   = 2'd1,
    MEM_WR   = 2'd2,
    MEM_WAIT = 2'd3
  } mem_fn_e;

  // first member is the MSB: mem [18:17], alu [16:14], switches [13:0]
  typedef struct packed {
    mem_fn_e mem;
    alu_fn_e alu;
    logic    mbr_ld;
    logic    mbr_drv;
    logic    mar_ld;
    logic    opnd_ld;
    logic    r2_ld;
    logic    r2_drv;
    logic    r1_ld;
    logic    r1_drv;
    logic    pc_ld;
    logic    pc_drv;
    logic    alu_in;
    logic    res_drv;
    logic    ira_drv;
    logic    ir_ld;
  } uword_t;

  localparam int unsigned UWORD_W = $bits(uword_t);
  localparam int unsigned NSRC    = 6;  // ira, res, pc, r1, r2, mbr
  localparam int unsigned NGR     = 6;  // ir, pc, r1, r2, opnd, mar

endpackage

// File: rtl/seqbus_ustore.sv
module seqbus_ustore
  import seqbus_pkg::*;
#(
  parameter int unsigned ROWS = 16,
  parameter int unsigned UAW  = 4
) (
  input  logic               clk_i,
  input  logic               we_i,
  input  logic [UAW-1:0]     waddr_i,
  input  logic [UWORD_W-1:0] wdata_i,
  input  logic [UAW-1:0]     raddr_i,
  output uword_t             row_o
);

  logic [UWORD_W-1:0] mem_q [ROWS];

  always_ff @(posedge clk_i) begin
    if (we_i) mem_q[waddr_i] <= wdata_i;
  end

  assign row_o = uword_t'(mem_q[raddr_i]);

endmodule

// File: rtl/seqbus_useq.sv
module seqbus_useq #(
  parameter int unsigned ROWS = 16,
  parameter int unsigned UAW  = 4
) (
  input  logic           clk_i,
  input  logic           rst_ni,
  input  logic           step_i,
  output logic [UAW-1:0] upc_o
);

  localparam logic [UAW-1:0] LAST = UAW'(ROWS - 1);

  logic [UAW-1:0] upc_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     upc_q <= '0;
    else if (step_i) upc_q <= (upc_q == LAST) ? '0 : upc_q + 1'b1;
  end

  assign upc_o = upc_q;

  // R9
  a_r9_upc_advance: assert property (@(posedge clk_i) disable iff (!rst_ni)
    step_i |=> upc_q == (($past(upc_q) == LAST) ? '0 : $past(upc_q) + 1'b1));

  // R7
  a_r7_upc_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !step_i |=> $stable(upc_q));

endmodule

// File: rtl/seqbus_alu.sv
module seqbus_alu
  import seqbus_pkg::*;
#(
  parameter int unsigned DW = 16
) (
  input  alu_fn_e       fn_i,
  input  logic [DW-1:0] bus_i,
  input  logic [DW-1:0] opnd_i,
  output logic [DW-1:0] y_o,
  output logic          act_o
);

  always_comb begin
    act_o = 1'b1;
    unique case (fn_i)
      ALU_ADD: y_o = opnd_i + bus_i;
      ALU_SUB: y_o = opnd_i - bus_i;
      ALU_INC: y_o = bus_i + 1'b1;
      ALU_DEC: y_o = bus_i - 1'b1;
      default: begin
        y_o   = '0;
        act_o = 1'b0;
      end
    endcase
  end

endmodule

// File: rtl/seqbus_memif.sv
module seqbus_memif #(
  parameter int unsigned DW = 16
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          launch_i,
  input  logic          wr_i,
  input  logic [DW-1:0] addr_d_i,
  input  logic [DW-1:0] wdata_d_i,
  input  logic          done_i,
  output logic          req_o,
  output logic          we_o,
  output logic [DW-1:0] addr_o,
  output logic [DW-1:0] wdata_o,
  output logic          busy_o,
  output logic          rd_done_o
);

  logic          pend_q, we_q;
  logic [DW-1:0] addr_q, wdata_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pend_q  <= 1'b0;
      we_q    <= 1'b0;
      addr_q  <= '0;
      wdata_q <= '0;
    end else if (launch_i) begin
      pend_q  <= 1'b1;
      we_q    <= wr_i;
      addr_q  <= addr_d_i;
      wdata_q <= wdata_d_i;
    end else if (done_i) begin
      pend_q  <= 1'b0;
    end
  end

  assign req_o     = pend_q;
  assign we_o      = we_q;
  assign addr_o    = addr_q;
  assign wdata_o   = wdata_q;
  assign busy_o    = pend_q & ~done_i;
  assign rd_done_o = pend_q & done_i & ~we_q;

  // R6
  a_r6_req_held: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_o && !done_i) |=> req_o && $stable(addr_o) && $stable(we_o));

  // R8: no launch may overwrite an operation still waiting
  a_r8_no_overrun: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_o && !done_i) |-> !launch_i);

endmodule

// File: rtl/seqbus_core.sv
module seqbus_core
  import seqbus_pkg::*;
#(
  parameter  int unsigned DW     = 16,
  parameter  int unsigned ADRF_W = 12,
  parameter  int unsigned UROWS  = 16,
  localparam int unsigned UAW    = (UROWS > 1) ? $clog2(UROWS) : 1
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               uc_we_i,
  input  logic [UAW-1:0]     uc_addr_i,
  input  logic [UWORD_W-1:0] uc_data_i,
  output logic               mem_req_o,
  output logic               mem_we_o,
  output logic [DW-1:0]      mem_addr_o,
  output logic [DW-1:0]      mem_wdata_o,
  input  logic [DW-1:0]      mem_rdata_i,
  input  logic               mem_done_i,
  output logic [DW-1:0]      bus_o,
  output logic [UAW-1:0]     upc_o
);

  localparam int unsigned GR_IR = 0, GR_PC = 1, GR_R1 = 2, GR_R2 = 3, GR_OPND = 4, GR_MAR = 5;

  uword_t         uw;
  logic [UAW-1:0] upc;
  logic           busy, step, launch, rd_done, alu_act;

  logic [DW-1:0]   gr_q [NGR];
  logic [DW-1:0]   res_q, mbr_q, mbr_d, mar_d, alu_y, bus;
  logic [NGR-1:0]  ld;
  logic [NSRC-1:0] drv;
  logic [DW-1:0]   src   [NSRC];
  logic [DW-1:0]   gated [NSRC];

  seqbus_ustore #(.ROWS(UROWS), .UAW(UAW)) u_store (
    .clk_i   (clk_i),
    .we_i    (uc_we_i),
    .waddr_i (uc_addr_i),
    .wdata_i (uc_data_i),
    .raddr_i (upc),
    .row_o   (uw)
  );

  seqbus_useq #(.ROWS(UROWS), .UAW(UAW)) u_seq (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .step_i (step),
    .upc_o  (upc)
  );

  // a row with any memory code stalls while an earlier operation is still open
  assign step   = ~(busy & (uw.mem != MEM_NOP));
  assign launch = step & ((uw.mem == MEM_RD) | (uw.mem == MEM_WR));

  // bus sources and switches
  assign src[0] = {{(DW-ADRF_W){1'b0}}, gr_q[GR_IR][ADRF_W-1:0]};
  assign src[1] = res_q;
  assign src[2] = gr_q[GR_PC];
  assign src[3] = gr_q[GR_R1];
  assign src[4] = gr_q[GR_R2];
  assign src[5] = mbr_q;
  assign drv    = {uw.mbr_drv, uw.r2_drv, uw.r1_drv, uw.pc_drv, uw.res_drv, uw.ira_drv};
  assign ld     = {uw.mar_ld, uw.opnd_ld, uw.r2_ld, uw.r1_ld, uw.pc_ld, uw.ir_ld};

  for (genvar g = 0; g < NSRC; g++) begin : g_sw
    assign gated[g] = src[g] & {DW{drv[g]}};
  end

  always_comb begin
    bus = '0;
    for (int i = 0; i < NSRC; i++) bus |= gated[i];
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < NGR; i++) gr_q[i] <= '0;
    end else if (step) begin
      for (int i = 0; i < NGR; i++) if (ld[i]) gr_q[i] <= bus;
    end
  end

  seqbus_alu #(.DW(DW)) u_alu (
    .fn_i   (uw.alu),
    .bus_i  (bus),
    .opnd_i (gr_q[GR_OPND]),
    .y_o    (alu_y),
    .act_o  (alu_act)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                           res_q <= '0;
    else if (step && uw.alu_in && alu_act) res_q <= alu_y;
  end

  // a row load of the data register wins over read data arriving in the same cycle
  always_comb begin
    mbr_d = mbr_q;
    if (step && uw.mbr_ld) mbr_d = bus;
    else if (rd_done)      mbr_d = mem_rdata_i;
  end

  assign mar_d = (step && uw.mar_ld) ? bus : gr_q[GR_MAR];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) mbr_q <= '0;
    else         mbr_q <= mbr_d;
  end

  seqbus_memif #(.DW(DW)) u_memif (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .launch_i  (launch),
    .wr_i      (uw.mem == MEM_WR),
    .addr_d_i  (mar_d),
    .wdata_d_i (mbr_d),
    .done_i    (mem_done_i),
    .req_o     (mem_req_o),
    .we_o      (mem_we_o),
    .addr_o    (mem_addr_o),
    .wdata_o   (mem_wdata_o),
    .busy_o    (busy),
    .rd_done_o (rd_done)
  );

  assign bus_o = bus;
  assign upc_o = upc;

  // R2
  a_r2_single_driver: assert property (@(posedge clk_i) disable iff (!rst_ni)
    step |-> $onehot0(drv));

  // R3
  a_r3_adr_zero_ext: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (drv == NSRC'(1)) |-> bus_o[DW-1:ADRF_W] == '0);

  // R5
  a_r5_alu_gated: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(step && uw.alu_in) |=> $stable(res_q));

  // R6
  a_r6_read_capture: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_done && !(step && uw.mbr_ld)) |=> mbr_q == $past(mem_rdata_i));

endmodule

// File: tb/seqbus_core_test.sv
module seqbus_core_test;

  localparam int IRL = 0, IRA = 1, RSD = 2, ALI = 3, PCD = 4, PCL = 5, R1D = 6, R1L = 7;
  localparam int R2D = 8, R2L = 9, OPL = 10, MRL = 11, MBD = 12, MBL = 13;
  localparam logic [2:0] F_NOP = 3'd0, F_ADD = 3'd1, F_SUB = 3'd2, F_INC = 3'd3, F_DEC = 3'd4;
  localparam logic [1:0] M_NOP = 2'd0, M_RD = 2'd1, M_WR = 2'd2, M_WT = 2'd3;

  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic        uc_we = 1'b0;
  logic [3:0]  uc_addr = '0;
  logic [18:0] uc_data = '0;
  logic        mem_req, mem_we, mem_done;
  logic [15:0] mem_addr, mem_wdata, mem_rdata, bus;
  logic [3:0]  upc;

  logic [15:0] mem [64];
  int          mem_lat = 0;
  int          total = 0;
  int          bad = 0;

  always #5 clk = ~clk;

  seqbus_core uut (
    .clk_i       (clk),
    .rst_ni      (rst_ni),
    .uc_we_i     (uc_we),
    .uc_addr_i   (uc_addr),
    .uc_data_i   (uc_data),
    .mem_req_o   (mem_req),
    .mem_we_o    (mem_we),
    .mem_addr_o  (mem_addr),
    .mem_wdata_o (mem_wdata),
    .mem_rdata_i (mem_rdata),
    .mem_done_i  (mem_done),
    .bus_o       (bus),
    .upc_o       (upc)
  );

  function automatic logic [13:0] b(input int i);
    return 14'(1 << i);
  endfunction

  // word layout per R10: {mem[1:0], fn[2:0], switches[13:0]}
  function automatic logic [18:0] row(input int r);
    case (r)
      0:  return {M_RD, F_INC, b(PCD) | b(MRL) | b(ALI)};
      1:  return {M_WT, F_NOP, b(RSD) | b(PCL)};
      2:  return {M_NOP, F_NOP, b(MBD) | b(IRL)};
      3:  return {M_RD, F_NOP, b(IRA) | b(MRL)};
      4:  return {M_WT, F_NOP, 14'd0};
      5:  return {M_NOP, F_NOP, b(MBD) | b(R1L)};
      6:  return {M_RD, F_NOP, b(PCD) | b(MRL)};
      7:  return {M_WT, F_NOP, b(R1D) | b(OPL)};
      8:  return {M_NOP, F_SUB, b(MBD) | b(R2L) | b(ALI)};
      9:  return {M_NOP, F_DEC, b(RSD) | b(MBL)};  // no unit input: code ignored (R5)
      10: return {M_WR, F_NOP, b(IRA) | b(MRL)};
      11: return {M_WT, F_NOP, b(RSD) | b(R1L)};
      12: return {M_NOP, F_ADD, b(R2D) | b(ALI)};
      13: return {M_NOP, F_NOP, b(RSD) | b(MBL)};
      14: return {M_NOP, F_DEC, b(IRA) | b(ALI)};
      default: return {M_WR, F_NOP, b(RSD) | b(MRL)};
    endcase
  endfunction

  task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  // memory model: done after mem_lat extra cycles of request
  initial begin
    int cnt;
    cnt = 0;
    mem_done = 1'b0;
    mem_rdata = '0;
    forever begin
      @(negedge clk);
      if (!rst_ni || mem_done) begin
        mem_done = 1'b0;
        cnt = 0;
      end else if (mem_req) begin
        if (cnt >= mem_lat) begin
          mem_done = 1'b1;
          if (mem_we) mem[mem_addr[5:0]] = mem_wdata;
          else        mem_rdata = mem[mem_addr[5:0]];
        end else begin
          cnt++;
        end
      end
    end
  end

  task automatic run_case(input int lat, input logic [15:0] a, input logic [15:0] bv, input int k);
    logic [15:0] x, bus3, bus11, bus0b;
    int n1, n0b;
    bit seen15, got3, got11, fin;
    x = 16'(16 + 4 * k);
    rst_ni = 1'b0;
    for (int i = 0; i < 64; i++) mem[i] = '0;
    mem[0] = 16'hF000 | x;
    mem[1] = bv;
    mem[x[5:0]] = a;
    mem_lat = lat;
    repeat (2) @(negedge clk);
    rst_ni = 1'b1;
    #1;
    chk("R1 upc", 16'(upc), 16'd0);
    chk("R1 req", 16'(mem_req), 16'd0);
    chk("R1 bus", bus, 16'd0);
    n1 = 0; n0b = 0; seen15 = 0; got3 = 0; got11 = 0; fin = 0;
    bus3 = '0; bus11 = '0; bus0b = '0;
    for (int c = 0; c < 400 && !fin; c++) begin
      @(negedge clk);
      #1;
      if (!seen15) begin
        if (upc == 4'd1) n1++;
        if (upc == 4'd3 && !got3) begin bus3 = bus; got3 = 1; end
        if (upc == 4'd11 && !got11) begin bus11 = bus; got11 = 1; end
        if (upc == 4'd15) seen15 = 1;
      end else begin
        if (upc == 4'd0) begin n0b++; bus0b = bus; end
        if (upc == 4'd1) fin = 1;
      end
    end
    chk("R7 R9 wait stall length", 16'(n1), 16'(lat + 1));
    chk("R3 address field on bus", bus3, x);
    chk("R5 R4 result after ignored code", bus11, a - bv);
    chk("R6 R10 write of difference", mem[x[5:0]], a - bv);
    chk("R2 R4 R6 write of sum at decremented address", mem[6'(x - 16'd1)], a + bv);
    chk("R9 R4 wrap to row 0 with incremented pc", bus0b, 16'd1);
    chk("R8 launch held behind write", 16'(n0b), 16'(lat + 1));
  endtask

  initial begin
    logic [15:0] av [6];
    logic [15:0] bvv [6];
    av[0] = 16'd5;      bvv[0] = 16'd3;
    av[1] = 16'd3;      bvv[1] = 16'd5;
    av[2] = 16'hFFFF;   bvv[2] = 16'd1;
    av[3] = 16'h8000;   bvv[3] = 16'h8000;
    av[4] = 16'd0;      bvv[4] = 16'd0;
    av[5] = 16'h1234;   bvv[5] = 16'h0FED;
    // R10: fill the store while held in reset
    for (int r = 0; r < 16; r++) begin
      @(negedge clk);
      uc_we = 1'b1;
      uc_addr = 4'(r);
      uc_data = row(r);
    end
    @(negedge clk);
    uc_we = 1'b0;
    for (int lat = 0; lat < 4; lat++)
      for (int k = 0; k < 6; k++)
        run_case(lat, av[k], bvv[k], k);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    total++;
    bad++;
    $display("FAIL watchdog expired act=running exp=finished");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule